// File: doc/BRIEF.md
# TDM Slot Router

The block sits between a TDM framer and a set of internal serial channels. It decides, for every time slot of a frame, which channel owns that slot, or whether no channel owns it. The framer supplies a frame-sync pulse and a per-bit strobe. The block counts bit positions inside each 8-bit slot itself. On the receive side it collects each slot's bits, most significant bit first, into a byte. It hands that byte to the owning channel with a one-cycle valid pulse. On the transmit side it picks the owning channel's byte and serialises it. It raises a request to that channel on the slot's first bit, and it fills slots that no channel owns with ones.

Ownership is described by two independent route tables, one per direction. Each table is a list of runs. A run is a pair made of a slot count and a channel code, and each run begins in the slot just after the previous run ends. A host writes runs through a single write port that gives the entry index, the count, the code and a flag marking the final entry. Each table keeps a shadow copy and an active copy, and a frame sync moves the shadow copy into the active one. A table therefore changes only between frames.

Top module: `tdm_slot_router`

## Requirements
- R1: A write with `cfg_we` high stores (count, code) at entry `cfg_idx` of the table chosen by `cfg_tx` (0 = receive, 1 = transmit); when `cfg_last` is 1 the table length becomes `cfg_idx`+1.
- R2: A write whose count is 0 or above 64, or whose code is above 5, changes nothing.
- R3: Runs apply in entry order from slot 0. Entry 0 covers its count of slots, and each later entry starts in the slot after the previous one ends. Example: (2,0),(24,3),(1,0),(5,2) gives slots 0–1 unused, 2–25 to channel code 3, 26 unused and 27–31 to channel code 2.
- R4: For a receive slot with code c in 1..5, one cycle after that slot's eighth bit strobe `rx_byte` holds the slot's bits (first received bit in bit 7), and `rx_vld` bit c-1 is high for exactly that cycle. At all other times `rx_vld` is 0.
- R5: For a transmit slot with code c in 1..5, during the strobe of bit b (b = 0..7) `tx_bit` equals bit 7-b of `tx_data[(c-1)*8 +: 8]`. `tx_req` bit c-1 is high only during the strobe of bit 0.
- R6: Slots with code 0, and all slots after the last entry of a table, are unused. They produce no `rx_vld`, no `tx_req`, and `tx_bit` = 1.
- R7: A write made during a frame does not change that frame's routing. It takes effect from the next `frm_sync`.
- R8: The receive and transmit tables are independent. Writing one does not change the routing of the other.
- R9: `frm_sync` restarts routing at entry 0, bit 0. A bit strobe in the same cycle as `frm_sync` is ignored.
- R10: A run of 64 slots and a table of 64 entries route correctly.
- R11: After reset both tables are empty, so every slot is unused until runs are written and a frame sync occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| frm_sync | input | 1 | Frame start; the next strobe is bit 0 of slot 0 |
| bit_en | input | 1 | One serial bit strobe |
| rx_bit | input | 1 | Received serial bit, valid with bit_en |
| rx_byte | output | 8 | Last completed receive slot byte |
| rx_vld | output | 5 | One-hot receive valid per channel |
| tx_data | input | 40 | Transmit byte of each channel, channel k at bits [8k+7:8k] |
| tx_req | output | 5 | One-hot transmit byte request per channel |
| tx_bit | output | 1 | Transmitted serial bit for the current strobe |
| cfg_we | input | 1 | Table write enable |
| cfg_tx | input | 1 | Table select: 0 receive, 1 transmit |
| cfg_idx | input | 6 | Entry index |
| cfg_cnt | input | 7 | Slot count of the run (1..64) |
| cfg_dst | input | 3 | Channel code (0 unused, 1..5 channel) |
| cfg_last | input | 1 | Marks this entry as the final one |

## Verification
`tx_bit` and `tx_req` are combinational on the current strobe. The bench reads them a quarter period before the edge that consumes that strobe. `rx_byte` and `rx_vld` are registered at the edge of a slot's eighth strobe, so they are due in the cycle of the next slot's first strobe. The bench checks them in that cycle, and checks them one idle cycle after the final slot of a frame. Table writes are due at the next frame sync: the bench's model copies its shadow tables to its active tables exactly when it drives `frm_sync`.

// File: rtl/tdm_route_pkg.sv
package tdm_route_pkg;
    localparam int DEF_NCH       = 5;
    localparam int DEF_SLOT_BITS = 8;
    localparam int DEF_DEPTH     = 64;
    localparam int DEF_MAX_RUN   = 64;

    typedef enum logic {
        DIR_RX = 1'b0,
        DIR_TX = 1'b1
    } route_dir_e;
endpackage

// File: rtl/tdm_route_table.sv
module tdm_route_table #(
    parameter int DEPTH = 64,
    parameter int CNT_W = 7,
    parameter int DST_W = 3,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int LEN_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [CNT_W-1:0] wr_cnt,
    input  logic [DST_W-1:0] wr_dst,
    input  logic             wr_last,
    input  logic             swap,
    input  logic [IDX_W-1:0] rd_cur,
    input  logic [IDX_W-1:0] rd_nxt,
    output logic [DST_W-1:0] cur_dst,
    output logic [CNT_W-1:0] nxt_cnt,
    output logic [CNT_W-1:0] head_cnt,
    output logic [LEN_W-1:0] act_len,
    output logic [LEN_W-1:0] shd_len
);
    logic [CNT_W-1:0] shd_cnt_q [DEPTH];
    logic [DST_W-1:0] shd_dst_q [DEPTH];
    logic [CNT_W-1:0] act_cnt_q [DEPTH];
    logic [DST_W-1:0] act_dst_q [DEPTH];
    logic [LEN_W-1:0] shd_len_q, act_len_q;

    // Shadow copy takes host writes; active copy follows it only on swap.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                shd_cnt_q[i] <= '0;
                shd_dst_q[i] <= '0;
                act_cnt_q[i] <= '0;
                act_dst_q[i] <= '0;
            end
            shd_len_q <= '0;
            act_len_q <= '0;
        end else begin
            if (swap) begin
                act_cnt_q <= shd_cnt_q;
                act_dst_q <= shd_dst_q;
                act_len_q <= shd_len_q;
            end
            if (wr_en) begin
                shd_cnt_q[wr_idx] <= wr_cnt;
                shd_dst_q[wr_idx] <= wr_dst;
                if (wr_last)
                    shd_len_q <= {1'b0, wr_idx} + LEN_W'(1);
            end
        end
    end

    assign cur_dst  = act_dst_q[rd_cur];
    assign nxt_cnt  = act_cnt_q[rd_nxt];
    assign head_cnt = shd_cnt_q[0];
    assign act_len  = act_len_q;
    assign shd_len  = shd_len_q;
endmodule

// File: rtl/tdm_run_walker.sv
module tdm_run_walker #(
    parameter int DEPTH = 64,
    parameter int CNT_W = 7,
    parameter int DST_W = 3,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int LEN_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync,
    input  logic             slot_end,
    input  logic [DST_W-1:0] cur_dst,
    input  logic [CNT_W-1:0] nxt_cnt,
    input  logic [CNT_W-1:0] head_cnt,
    input  logic [LEN_W-1:0] act_len,
    input  logic [LEN_W-1:0] shd_len,
    output logic [IDX_W-1:0] rd_cur,
    output logic [IDX_W-1:0] rd_nxt,
    output logic [DST_W-1:0] slot_dst
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] rem;
        logic             done;
    } walk_t;

    walk_t w_q, w_d;
    logic [LEN_W-1:0] idx_next;

    assign idx_next = {1'b0, w_q.idx} + LEN_W'(1);

    always_comb begin
        w_d = w_q;
        if (sync) begin
            // Shadow becomes active on this edge, so seed from the shadow head.
            w_d.idx  = '0;
            w_d.rem  = head_cnt;
            w_d.done = (shd_len == '0);
        end else if (slot_end && !w_q.done) begin
            if (w_q.rem <= CNT_W'(1)) begin
                if (idx_next >= act_len) begin
                    w_d.done = 1'b1;
                end else begin
                    w_d.idx = idx_next[IDX_W-1:0];
                    w_d.rem = nxt_cnt;
                end
            end else begin
                w_d.rem = w_q.rem - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '{idx: '0, rem: '0, done: 1'b1};
        end else begin
            w_q <= w_d;
        end
    end

    assign rd_cur   = w_q.idx;
    assign rd_nxt   = idx_next[IDX_W-1:0];
    assign slot_dst = w_q.done ? '0 : cur_dst;
endmodule

// File: rtl/tdm_slot_router.sv
module tdm_slot_router
    import tdm_route_pkg::*;
#(
    parameter int NCH       = DEF_NCH,
    parameter int SLOT_BITS = DEF_SLOT_BITS,
    parameter int DEPTH     = DEF_DEPTH,
    parameter int MAX_RUN   = DEF_MAX_RUN,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(MAX_RUN + 1),
    localparam int DST_W = $clog2(NCH + 1),
    localparam int BIT_W = $clog2(SLOT_BITS),
    localparam int LEN_W = IDX_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frm_sync,
    input  logic                     bit_en,
    input  logic                     rx_bit,
    output logic [SLOT_BITS-1:0]     rx_byte,
    output logic [NCH-1:0]           rx_vld,
    input  logic [NCH*SLOT_BITS-1:0] tx_data,
    output logic [NCH-1:0]           tx_req,
    output logic                     tx_bit,
    input  logic                     cfg_we,
    input  logic                     cfg_tx,
    input  logic [IDX_W-1:0]         cfg_idx,
    input  logic [CNT_W-1:0]         cfg_cnt,
    input  logic [DST_W-1:0]         cfg_dst,
    input  logic                     cfg_last
);
    typedef struct packed {
        logic [BIT_W-1:0]     bitpos;
        logic [SLOT_BITS-1:0] sr;
        logic [SLOT_BITS-1:0] rx_byte;
        logic [NCH-1:0]       rx_vld;
    } rtr_t;

    rtr_t st_q, st_d;

    logic bit_live, slot_end, first_bit, cfg_ok;
    logic [1:0]       tbl_we;
    logic [DST_W-1:0] dst_w [2];
    logic [DST_W-1:0] rx_dst, tx_dst;
    logic [SLOT_BITS-1:0] tx_sel, tx_sh;

    assign bit_live  = bit_en && !frm_sync;
    assign first_bit = bit_live && (st_q.bitpos == '0);
    assign slot_end  = bit_live && (st_q.bitpos == BIT_W'(SLOT_BITS - 1));
    assign cfg_ok    = (cfg_cnt != '0) && (cfg_cnt <= CNT_W'(MAX_RUN))
                    && (cfg_dst <= DST_W'(NCH));
    assign tbl_we[DIR_RX] = cfg_we && cfg_ok && (cfg_tx == DIR_TX ? 1'b0 : 1'b1);
    assign tbl_we[DIR_TX] = cfg_we && cfg_ok && (cfg_tx == DIR_TX);

    for (genvar g = 0; g < 2; g++) begin : g_dir
        logic [IDX_W-1:0] rd_cur, rd_nxt;
        logic [DST_W-1:0] cur_dst;
        logic [CNT_W-1:0] nxt_cnt, head_cnt;
        logic [LEN_W-1:0] act_len, shd_len;

        tdm_route_table #(.DEPTH(DEPTH), .CNT_W(CNT_W), .DST_W(DST_W)) u_table (
            .clk(clk), .rst_n(rst_n),
            .wr_en(tbl_we[g]), .wr_idx(cfg_idx), .wr_cnt(cfg_cnt),
            .wr_dst(cfg_dst), .wr_last(cfg_last),
            .swap(frm_sync), .rd_cur(rd_cur), .rd_nxt(rd_nxt),
            .cur_dst(cur_dst), .nxt_cnt(nxt_cnt), .head_cnt(head_cnt),
            .act_len(act_len), .shd_len(shd_len)
        );

        tdm_run_walker #(.DEPTH(DEPTH), .CNT_W(CNT_W), .DST_W(DST_W)) u_walk (
            .clk(clk), .rst_n(rst_n),
            .sync(frm_sync), .slot_end(slot_end),
            .cur_dst(cur_dst), .nxt_cnt(nxt_cnt), .head_cnt(head_cnt),
            .act_len(act_len), .shd_len(shd_len),
            .rd_cur(rd_cur), .rd_nxt(rd_nxt), .slot_dst(dst_w[g])
        );
    end

    assign rx_dst = dst_w[DIR_RX];
    assign tx_dst = dst_w[DIR_TX];

    // Receive: bit counter, shift register, per-channel byte hand-off.
    always_comb begin
        st_d        = st_q;
        st_d.rx_vld = '0;
        if (frm_sync) begin
            st_d.bitpos = '0;
        end else if (bit_en) begin
            st_d.sr     = {st_q.sr[SLOT_BITS-2:0], rx_bit};
            st_d.bitpos = slot_end ? '0 : st_q.bitpos + BIT_W'(1);
            if (slot_end) begin
                st_d.rx_byte = {st_q.sr[SLOT_BITS-2:0], rx_bit};
                for (int k = 0; k < NCH; k++)
                    st_d.rx_vld[k] = (rx_dst == DST_W'(k + 1));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_byte = st_q.rx_byte;
    assign rx_vld  = st_q.rx_vld;

    // Transmit: owner's byte, MSB first; unowned slots idle at all ones.
    always_comb begin
        tx_sel = '1;
        tx_req = '0;
        for (int k = 0; k < NCH; k++) begin
            if (tx_dst == DST_W'(k + 1)) begin
                tx_sel    = tx_data[k*SLOT_BITS +: SLOT_BITS];
                tx_req[k] = first_bit;
            end
        end
    end

    assign tx_sh  = tx_sel << st_q.bitpos;
    assign tx_bit = tx_sh[SLOT_BITS-1];
endmodule

// File: rtl/tdm_slot_router_chk.sv
module tdm_slot_router_chk #(
    parameter int NCH   = 5,
    parameter int DST_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frm_sync,
    input logic             bit_en,
    input logic [NCH-1:0]   rx_vld,
    input logic [NCH-1:0]   tx_req,
    input logic             tx_bit,
    input logic [DST_W-1:0] tx_dst
);
    // R4
    rx_vld_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rx_vld));

    // R4
    rx_vld_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_vld != '0) |-> $past(bit_en && !frm_sync));

    // R5
    tx_req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tx_req));

    // R9
    tx_req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req != '0) |-> (bit_en && !frm_sync));

    // R6
    idle_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && tx_dst == '0) |-> tx_bit);

    // R9
    sync_no_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_sync |=> (rx_vld == '0));
endmodule

bind tdm_slot_router tdm_slot_router_chk #(.NCH(NCH), .DST_W(DST_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .frm_sync(frm_sync), .bit_en(bit_en),
    .rx_vld(rx_vld), .tx_req(tx_req), .tx_bit(tx_bit), .tx_dst(tx_dst)
);

// File: tb/test_tdm_slot_router.sv
module test_tdm_slot_router;
    localparam int CLK_P = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic frm_sync = 1'b0, bit_en = 1'b0, rx_bit = 1'b0;
    logic [7:0]  rx_byte;
    logic [4:0]  rx_vld, tx_req;
    logic [39:0] tx_data = '0;
    logic        tx_bit;
    logic        cfg_we = 1'b0, cfg_tx = 1'b0, cfg_last = 1'b0;
    logic [5:0]  cfg_idx = '0;
    logic [6:0]  cfg_cnt = '0;
    logic [2:0]  cfg_dst = '0;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    int m_cnt [2][64];
    int m_dst [2][64];
    int m_len [2];
    int a_cnt [2][64];
    int a_dst [2][64];
    int a_len [2];

    always #(CLK_P/2) clk = ~clk;

    tdm_slot_router i_tdm_slot_router (
        .clk(clk), .rst_n(rst_n), .frm_sync(frm_sync), .bit_en(bit_en),
        .rx_bit(rx_bit), .rx_byte(rx_byte), .rx_vld(rx_vld),
        .tx_data(tx_data), .tx_req(tx_req), .tx_bit(tx_bit),
        .cfg_we(cfg_we), .cfg_tx(cfg_tx), .cfg_idx(cfg_idx),
        .cfg_cnt(cfg_cnt), .cfg_dst(cfg_dst), .cfg_last(cfg_last)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_dst(int dir, int slot);
        int s = slot;
        for (int e = 0; e < a_len[dir]; e++) begin
            if (s < a_cnt[dir][e]) return a_dst[dir][e];
            s -= a_cnt[dir][e];
        end
        return 0;
    endfunction

    function automatic logic [7:0] pat(int fr, int s);
        return 8'((s * 37 + fr * 101 + 13) & 255);
    endfunction

    function automatic logic [4:0] onehot(int d);
        return (d == 0) ? 5'd0 : 5'(1 << (d - 1));
    endfunction

    task automatic cfg(bit tx, int idx, int cnt, int dst, bit last);
        @(negedge clk);
        cfg_we = 1'b1; cfg_tx = tx; cfg_idx = 6'(idx);
        cfg_cnt = 7'(cnt); cfg_dst = 3'(dst); cfg_last = last;
        if (cnt >= 1 && cnt <= 64 && dst <= 5) begin
            m_cnt[tx][idx] = cnt;
            m_dst[tx][idx] = dst;
            if (last) m_len[tx] = idx + 1;
        end
        @(negedge clk);
        cfg_we = 1'b0; cfg_last = 1'b0;
    endtask

    task automatic check_rx(string tag, int fr, int s);
        int d = exp_dst(0, s);
        chk({tag, " R4 rx_vld"}, 64'(rx_vld), 64'(onehot(d)));
        if (d != 0) chk({tag, " R4 rx_byte"}, 64'(rx_byte), 64'(pat(fr, s)));
    endtask

    // Drives one frame from the negedge; checks a quarter period before each edge.
    task automatic run_frame(string tag, int fr, int nslots, bit sync_bit);
        @(negedge clk);
        frm_sync = 1'b1; bit_en = sync_bit; rx_bit = 1'b1;
        a_cnt = m_cnt; a_dst = m_dst; a_len = m_len;
        #(CLK_P/4);
        chk({tag, " R9 tx_req at sync"}, 64'(tx_req), 64'd0);
        @(negedge clk);
        frm_sync = 1'b0;
        for (int s = 0; s < nslots; s++) begin
            for (int b = 0; b < 8; b++) begin
                int dt = exp_dst(1, s);
                logic [7:0] byt = tx_data[(dt > 0 ? dt - 1 : 0)*8 +: 8];
                bit_en = 1'b1;
                rx_bit = pat(fr, s)[7-b];
                #(CLK_P/4);
                chk({tag, (dt == 0) ? " R6 tx_bit" : " R5 tx_bit"},
                    64'(tx_bit), (dt == 0) ? 64'd1 : 64'(byt[7-b]));
                chk({tag, (dt == 0) ? " R6 tx_req" : " R5 tx_req"},
                    64'(tx_req), (b == 0) ? 64'(onehot(dt)) : 64'd0);
                if (b == 0 && s > 0) check_rx(tag, fr, s - 1);
                else chk({tag, " R4 rx_vld idle"}, 64'(rx_vld), 64'd0);
                @(negedge clk);
            end
        end
        bit_en = 1'b0;
        #(CLK_P/4);
        check_rx(tag, fr, nslots - 1);
        @(negedge clk);
    endtask

    initial begin
        for (int d = 0; d < 2; d++) begin
            m_len[d] = 0; a_len[d] = 0;
            for (int i = 0; i < 64; i++) begin
                m_cnt[d][i] = 0; m_dst[d][i] = 0;
            end
        end
        tx_data = {8'hE1, 8'h4C, 8'h96, 8'h2B, 8'hD5};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #(CLK_P/4);
        // R11: idle outputs after reset
        chk("R11 rx_vld", 64'(rx_vld), 64'd0);
        chk("R11 tx_req", 64'(tx_req), 64'd0);
        chk("R11 tx_bit", 64'(tx_bit), 64'd1);

        // R11: empty tables route nothing
        run_frame("R11 empty", 0, 32, 1'b0);

        // R1 R3: worked example on both tables
        cfg(0, 0, 2, 0, 0); cfg(0, 1, 24, 3, 0); cfg(0, 2, 1, 0, 0); cfg(0, 3, 5, 2, 1);
        cfg(1, 0, 2, 0, 0); cfg(1, 1, 24, 3, 0); cfg(1, 2, 1, 0, 0); cfg(1, 3, 5, 2, 1);
        run_frame("R1 R3 example", 1, 32, 1'b0);

        // R8: rewrite only the transmit table
        cfg(1, 0, 4, 1, 0); cfg(1, 1, 4, 2, 0); cfg(1, 2, 4, 3, 0);
        cfg(1, 3, 4, 4, 0); cfg(1, 4, 4, 5, 0); cfg(1, 5, 12, 0, 1);
        tx_data = {8'h5A, 8'hC3, 8'h0F, 8'h81, 8'h7E};
        run_frame("R8 split", 2, 32, 1'b0);

        // R7: receive table rewritten mid-frame, old routes hold until sync
        fork
            run_frame("R7 old", 3, 32, 1'b0);
            begin
                repeat (60) @(negedge clk);
                cfg(0, 0, 8, 5, 0);
                cfg(0, 1, 24, 1, 1);
            end
        join
        run_frame("R7 new", 4, 32, 1'b0);

        // R6: slots after the final entry are unused
        cfg(0, 0, 3, 1, 1);
        cfg(1, 0, 2, 2, 1);
        run_frame("R6 tail", 5, 8, 1'b0);

        // R10: a 64-slot run followed by a short one
        cfg(0, 0, 64, 4, 0); cfg(0, 1, 6, 5, 1);
        cfg(1, 0, 64, 3, 0); cfg(1, 1, 6, 1, 1);
        run_frame("R10 long run", 6, 70, 1'b0);

        // R10: full 64-entry tables, every code in rotation
        for (int i = 0; i < 64; i++) begin
            cfg(0, i, 1, i % 6, i == 63);
            cfg(1, i, 1, (i + 3) % 6, i == 63);
        end
        run_frame("R10 full table", 7, 66, 1'b0);

        // R2: malformed writes leave the tables untouched
        cfg(0, 0, 0, 1, 1);
        cfg(0, 0, 65, 2, 1);
        cfg(1, 0, 3, 6, 1);
        cfg(1, 5, 3, 7, 1);
        run_frame("R2 ignored", 8, 64, 1'b0);

        // R9: strobe coinciding with sync is dropped
        run_frame("R9 sync strobe", 9, 64, 1'b1);

        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=expired expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule